// File: doc/BRIEF.md
# I2C Bus Bit-Timing Generator

This block produces the SCL and SDA line waveforms for an I2C master from a fast function clock. A controller above it issues one command strobe at a time: start, send a bit, sample a bit, or stop. It then waits for a one-cycle completion pulse. The block turns each command into a timed sequence of line edges. Both lines are driven as open-drain pull-down enables, so a logic 1 on an output means the line is pulled low.

All edge positions come from software-set counts. There are two 16-bit dividers. An SCL low phase lasts 8·l cycles and a high phase lasts 8·h cycles, where l and h are each divider plus one. Within a low phase, SDA moves at a point set by a phase count s, in steps of l. The START setup and hold times and the STOP setup time are whole multiples of an SCL high period, set by their own counts u and p. The dividers and counts are captured when a command is accepted. Software can therefore prepare the next setting while a command is still running.

Top module: `i2c_bit_timer`

## Requirements
- R1: While reset is asserted and after it is released, both line outputs are released (0), and `busy` and `done` are 0.
- R2: The divider word holds the high divider in bits [31:16] and the low divider in bits [15:0], with l = low+1 and h = high+1. A divider field of 0 behaves as 1, so l and h are never below 2.
- R3: A send or sample command releases SCL 8·l−1 cycles after its accepting edge. When it is issued in a `done` cycle, SCL therefore stays low for exactly 8·l cycles. SCL is pulled again 8·h cycles after its release.
- R4: In a send command, SDA takes its new value l·s cycles after the accepting edge, which is l·s+1 cycles after SCL fell when issued in a `done` cycle. Here s = control bits [10:8] + 1, and a field value of 7 is handled as 6.
- R5: A START from the idle bus pulls SDA 8·h·u+1 cycles after the accepting edge and pulls SCL 8·h·(u+1)−1 cycles after that. Here u = control bits [13:12] + 1.
- R6: A START while the bus is held first releases SDA l·s cycles after acceptance, with SCL still low. It then releases SCL at 8·l−1 and applies the timing of R5, measured from the SCL release.
- R7: A STOP pulls SDA l·s cycles after acceptance and releases SCL at 8·l−1. It releases SDA 8·h·p+1 cycles after the SCL release, with p = control bits [15:14] + 1, and the bus then returns to idle.
- R8: A sample command releases SDA during its low phase. `rx_bit` takes the SDA line level at the clock edge that ends SCL high, and is valid from the `done` cycle on.
- R9: Every accepted command ends with exactly one single-cycle `done` pulse. The SCL pull that ends a start, send or sample command happens in the same cycle. `busy` is 0 in the `done` cycle.
- R10: Commands are ignored while `busy` is 1. Send, sample and stop are ignored on an idle bus.
- R11: Divider and control words are captured at the accepting edge. Changes made later have no effect on the running command.
- R12: When several strobes are high together, start wins over stop, stop over send, and send over sample.
- R13: During send and sample commands, SDA does not change while SCL is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_word | input | 32 | High divider [31:16], low divider [15:0] |
| ctrl_word | input | 16 | SDA phase count [10:8], start count [13:12], stop count [15:14] |
| cmd_start | input | 1 | Request START or repeated START |
| cmd_stop | input | 1 | Request STOP |
| cmd_send | input | 1 | Request transmission of `data_in` |
| cmd_sample | input | 1 | Request reception of one bit |
| data_in | input | 1 | Bit to transmit |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pd | output | 1 | SCL pull-down enable |
| sda_pd | output | 1 | SDA pull-down enable |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Last sampled bit |

## Verification
Every line edge of this block is due at a fixed number of clock cycles after the edge that accepted the command. That offset comes from l, h, s, u and p: for example l·s for the SDA update, 8·l−1 for the SCL release, and 8·h·u+1 after that release for the START SDA fall. The bench notes the cycle count at the accepting edge. It timestamps every change of `scl_pd`, `sda_pd` and `done` on the falling clock edge after the register update, and compares each offset with the value it computes from the configuration. Back-to-back commands are issued in the `done` cycle itself, so the full SCL low time of 8·l can be measured across two commands.

// File: rtl/i2c_bt_pkg.sv
// Package: shared types of the I2C bit-timing generator.
// Assumes: state encodings are private to the block; nothing outside decodes them.
package i2c_bt_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,   // bus free, both lines released
        ST_HELD,   // bus owned, SCL pulled low between commands
        ST_LOW,    // SCL low phase of a command
        ST_HIGH,   // SCL high phase of a data bit
        ST_SU,     // SCL high, waiting for START setup
        ST_HD,     // SDA low, waiting for START hold
        ST_STO     // SCL high, waiting for STOP setup
    } bt_state_e;

    // What the current low phase prepares for
    typedef enum logic [1:0] {
        LK_DATA,   // drive a transmitted bit
        LK_SAMP,   // release SDA for the target to drive
        LK_RSTART, // release SDA ahead of a repeated START
        LK_STOP    // pull SDA ahead of a STOP
    } bt_low_e;

    // Captured phase counts (field widths fixed by the control word layout)
    typedef struct packed {
        logic [2:0] sda;
        logic [1:0] sta;
        logic [1:0] sto;
    } bt_phase_t;

endpackage

// File: rtl/i2c_bt_timing.sv
// Module: i2c_bt_timing
// Captures the divider and control words when a command is accepted and
// derives the counter thresholds for every phase edge.
// Assumes: thresholds are compared against a counter that reads 0 in the
// first cycle of a phase; the caller loads only on command acceptance.
module i2c_bt_timing
    import i2c_bt_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = DIV_W + 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [2*DIV_W-1:0] div_word,
    input  logic [15:0]        ctrl_word,
    output logic [CNT_W-1:0]   t_sda,
    output logic [CNT_W-1:0]   t_low,
    output logic [CNT_W-1:0]   t_high,
    output logic [CNT_W-1:0]   t_su,
    output logic [CNT_W-1:0]   t_hd,
    output logic [CNT_W-1:0]   t_sto
);

    localparam logic [CNT_W-1:0] C1 = CNT_W'(1);
    localparam logic [CNT_W-1:0] C2 = CNT_W'(2);

    logic [2*DIV_W-1:0] div_q;
    bt_phase_t          ph_q;
    logic [CNT_W-1:0]   l_w, h_w, s_w, u_w, p_w;
    logic               unused_ctrl;

    assign unused_ctrl = ^{ctrl_word[7:0], ctrl_word[11]};

    // One capture register per divider; index 0 is low, index 1 is high
    for (genvar g = 0; g < 2; g++) begin : g_div
        logic [DIV_W-1:0] raw;
        logic [DIV_W-1:0] q;
        assign raw = div_word[g*DIV_W +: DIV_W];
        // capture a divider at acceptance, replacing zero by one
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= DIV_W'(1);
            else if (load)
                q <= (raw == '0) ? DIV_W'(1) : raw;
        end
        assign div_q[g*DIV_W +: DIV_W] = q;
    end

    // capture phase counts at acceptance, clamping the SDA count to 6
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (load) begin
            ph_q.sda <= (ctrl_word[10:8] == 3'd7) ? 3'd6 : ctrl_word[10:8];
            ph_q.sta <= ctrl_word[13:12];
            ph_q.sto <= ctrl_word[15:14];
        end
    end

    // derive phase thresholds from the captured settings
    always_comb begin
        l_w    = CNT_W'(div_q[DIV_W-1:0]) + C1;
        h_w    = CNT_W'(div_q[2*DIV_W-1:DIV_W]) + C1;
        s_w    = CNT_W'(ph_q.sda) + C1;
        u_w    = CNT_W'(ph_q.sta) + C1;
        p_w    = CNT_W'(ph_q.sto) + C1;
        t_sda  = (l_w * s_w) - C1;
        t_low  = (l_w << 3) - C2;
        t_high = (h_w << 3) - C1;
        t_su   = (h_w * u_w) << 3;
        t_hd   = ((h_w * (u_w + C1)) << 3) - C2;
        t_sto  = (h_w * p_w) << 3;
    end

endmodule

// File: rtl/i2c_bt_count.sv
// Module: i2c_bt_count
// Phase counter: cleared at the start of each phase, counts while enabled.
// Assumes: clear has priority over enable; wrap-around is never reached
// because thresholds stay below 2**CNT_W.
module i2c_bt_count #(
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    // count cycles spent in the current phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en)
            cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/i2c_bit_timer.sv
// Module: i2c_bit_timer (top)
// Sequences START, repeated START, data bit, sample and STOP waveforms on
// open-drain SCL/SDA enables, placing each edge at a programmed count.
// Assumes: one command per done pulse; no clock stretching or arbitration;
// sda_in is already synchronous to clk.
module i2c_bit_timer
    import i2c_bt_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*DIV_W-1:0] div_word,
    input  logic [15:0]        ctrl_word,
    input  logic               cmd_start,
    input  logic               cmd_stop,
    input  logic               cmd_send,
    input  logic               cmd_sample,
    input  logic               data_in,
    input  logic               sda_in,
    output logic               scl_pd,
    output logic               sda_pd,
    output logic               busy,
    output logic               done,
    output logic               rx_bit
);

    localparam int CNT_W = DIV_W + 7;

    bt_state_e        state_q;
    bt_low_e          kind_q;
    logic             data_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] t_sda, t_low, t_high, t_su, t_hd, t_sto;
    logic             at_idle, at_held;
    logic             go_start, go_stop, go_send, go_samp, accept;
    logic             phase_hit, sda_hit;

    // decode the state and the prioritised command strobes
    always_comb begin
        at_idle  = (state_q == ST_IDLE);
        at_held  = (state_q == ST_HELD);
        go_start = cmd_start && (at_idle || at_held);
        go_stop  = !cmd_start && cmd_stop && at_held;
        go_send  = !cmd_start && !cmd_stop && cmd_send && at_held;
        go_samp  = !cmd_start && !cmd_stop && !cmd_send && cmd_sample && at_held;
        accept   = go_start || go_stop || go_send || go_samp;
    end

    // detect the end of the current phase and the SDA update point
    always_comb begin
        unique case (state_q)
            ST_LOW:  phase_hit = (cnt == t_low);
            ST_HIGH: phase_hit = (cnt == t_high);
            ST_SU:   phase_hit = (cnt == t_su);
            ST_HD:   phase_hit = (cnt == t_hd);
            ST_STO:  phase_hit = (cnt == t_sto);
            default: phase_hit = 1'b0;
        endcase
        sda_hit = (state_q == ST_LOW) && (cnt == t_sda);
    end

    assign busy = !(at_idle || at_held);

    i2c_bt_timing #(
        .DIV_W (DIV_W),
        .CNT_W (CNT_W)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .div_word  (div_word),
        .ctrl_word (ctrl_word),
        .t_sda     (t_sda),
        .t_low     (t_low),
        .t_high    (t_high),
        .t_su      (t_su),
        .t_hd      (t_hd),
        .t_sto     (t_sto)
    );

    i2c_bt_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .clr   (accept || phase_hit),
        .cnt   (cnt)
    );

    // sequence the phases and drive the line enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= LK_DATA;
            data_q  <= 1'b0;
            scl_pd  <= 1'b0;
            sda_pd  <= 1'b0;
            done    <= 1'b0;
            rx_bit  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (go_start)
                        state_q <= ST_SU;
                end
                ST_HELD: begin
                    if (go_start) begin
                        state_q <= ST_LOW;
                        kind_q  <= LK_RSTART;
                    end else if (go_stop) begin
                        state_q <= ST_LOW;
                        kind_q  <= LK_STOP;
                    end else if (go_send) begin
                        state_q <= ST_LOW;
                        kind_q  <= LK_DATA;
                        data_q  <= data_in;
                    end else if (go_samp) begin
                        state_q <= ST_LOW;
                        kind_q  <= LK_SAMP;
                    end
                end
                ST_LOW: begin
                    if (sda_hit) begin
                        unique case (kind_q)
                            LK_DATA: sda_pd <= !data_q;
                            LK_STOP: sda_pd <= 1'b1;
                            default: sda_pd <= 1'b0;
                        endcase
                    end
                    if (phase_hit) begin
                        scl_pd <= 1'b0;
                        unique case (kind_q)
                            LK_RSTART: state_q <= ST_SU;
                            LK_STOP:   state_q <= ST_STO;
                            default:   state_q <= ST_HIGH;
                        endcase
                    end
                end
                ST_HIGH: begin
                    if (phase_hit) begin
                        scl_pd  <= 1'b1;
                        done    <= 1'b1;
                        state_q <= ST_HELD;
                        if (kind_q == LK_SAMP)
                            rx_bit <= sda_in;
                    end
                end
                ST_SU: begin
                    if (phase_hit) begin
                        sda_pd  <= 1'b1;
                        state_q <= ST_HD;
                    end
                end
                ST_HD: begin
                    if (phase_hit) begin
                        scl_pd  <= 1'b1;
                        done    <= 1'b1;
                        state_q <= ST_HELD;
                    end
                end
                ST_STO: begin
                    if (phase_hit) begin
                        sda_pd  <= 1'b0;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_bit_timer_chk.sv
// Module: i2c_bit_timer_chk
// Protocol checker bound into i2c_bit_timer: line ordering and done rules.
// Assumes: sampled on the function clock, disabled during reset.
module i2c_bit_timer_chk
    import i2c_bt_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_pd,
    input logic      sda_pd,
    input logic      busy,
    input logic      done,
    input bt_state_e state
);

    // R1: an idle bus has both lines released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!scl_pd && !sda_pd));

    // R9: done lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy is low in the done cycle
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: SCL is only pulled low as a command completes
    a_r3_scl_pull_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pd) |-> done);

    // R13: SDA steady while SCL is released in a data bit
    a_r13_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_pd && $past(!scl_pd) && ($past(state) == ST_HIGH)) |-> $stable(sda_pd));

    // R5: SDA falls under a released SCL only as a START
    a_r5_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pd) && !scl_pd && $past(!scl_pd)) |-> (state == ST_HD));

    // R7: SDA rises under a released SCL only as a STOP
    a_r7_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_pd) && !scl_pd && $past(!scl_pd)) |-> (state == ST_IDLE));

endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_pd (scl_pd),
    .sda_pd (sda_pd),
    .busy   (busy),
    .done   (done),
    .state  (state_q)
);

// File: tb/i2c_bit_timer_tb_top.sv
// Directed bench for i2c_bit_timer: each task runs one scenario and checks
// the cycle offsets of every line edge against values computed here.
module i2c_bit_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2*DIV_W-1:0] div_word = '0;
    logic [15:0]        ctrl_word = '0;
    logic               cmd_start = 1'b0, cmd_stop = 1'b0;
    logic               cmd_send = 1'b0, cmd_sample = 1'b0;
    logic               data_in = 1'b0, slave_pd = 1'b0;
    logic               sda_in;
    logic               scl_pd, sda_pd, busy, done, rx_bit;

    assign sda_in = !(sda_pd || slave_pd);

    i2c_bit_timer #(.DIV_W(DIV_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_word   (div_word),
        .ctrl_word  (ctrl_word),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .cmd_send   (cmd_send),
        .cmd_sample (cmd_sample),
        .data_in    (data_in),
        .sda_in     (sda_in),
        .scl_pd     (scl_pd),
        .sda_pd     (sda_pd),
        .busy       (busy),
        .done       (done),
        .rx_bit     (rx_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // edge timestamps, taken on the falling clock edge
    logic scl_q = 1'b0, sda_q = 1'b0;
    int t_scl_rel = -1, t_scl_pull = -1, t_sda_rel = -1, t_sda_pull = -1;
    int t_sda_any = -1, t_done = -1, n_done = 0;
    always @(negedge clk) begin
        if (scl_pd !== scl_q) begin
            if (scl_pd) t_scl_pull = cyc; else t_scl_rel = cyc;
        end
        if (sda_pd !== sda_q) begin
            t_sda_any = cyc;
            if (sda_pd) t_sda_pull = cyc; else t_sda_rel = cyc;
        end
        if (done) begin
            t_done = cyc;
            n_done++;
        end
        scl_q = scl_pd;
        sda_q = sda_pd;
    end

    int n_chk = 0, n_fail = 0;
    int c0 = 0;
    int el = 2, eh = 2, es = 1, eu = 1, ep = 1;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // program words and the expected l, h, s, u, p
    task automatic set_cfg(input int dl, input int dh, input int s, input int u, input int p);
        div_word  = {dh[15:0], dl[15:0]};
        ctrl_word = 16'((s << 8) | (u << 12) | (p << 14));
        el = ((dl == 0) ? 1 : dl) + 1;
        eh = ((dh == 0) ? 1 : dh) + 1;
        es = ((s == 7) ? 6 : s) + 1;
        eu = u + 1;
        ep = p + 1;
    endtask

    // present strobes now; return just after the accepting edge
    task automatic issue(input logic st, input logic sp, input logic sd,
                         input logic sm, input logic d);
        cmd_start = st; cmd_stop = sp; cmd_send = sd; cmd_sample = sm; data_in = d;
        @(posedge clk);
        #1;
        c0 = cyc;
        t_scl_rel = -1; t_scl_pull = -1; t_sda_rel = -1; t_sda_pull = -1;
        t_sda_any = -1; t_done = -1;
        cmd_start = 0; cmd_stop = 0; cmd_send = 0; cmd_sample = 0;
    endtask

    task automatic wait_done();
        int k = 0;
        while (!done && k < 20000) begin
            step();
            k++;
        end
    endtask

    task automatic t_start_idle(input string tag);
        int su;
        issue(1, 0, 0, 0, 0);
        wait_done();
        su = 8*eh*eu + 1;
        check({tag, " R5 sda fall"}, t_sda_pull - c0, su);
        check({tag, " R5 scl fall"}, t_scl_pull - c0, su + 8*eh*(eu+1) - 1);
        check({tag, " R9 done"}, t_done - c0, su + 8*eh*(eu+1) - 1);
    endtask

    task automatic t_send(input string tag, input logic d);
        int prev_fall;
        logic chg;
        prev_fall = t_scl_pull;
        chg = (sda_pd != !d);
        issue(0, 0, 1, 0, d);
        wait_done();
        check({tag, " R4 sda value"}, int'(sda_pd), int'(!d));
        if (chg) check({tag, " R4 sda update"}, t_sda_any - c0, el*es);
        check({tag, " R3 scl release"}, t_scl_rel - c0, 8*el - 1);
        check({tag, " R3 low time"}, t_scl_rel - prev_fall, 8*el);
        check({tag, " R3 scl pull"}, t_scl_pull - t_scl_rel, 8*eh);
        check({tag, " R13 sda before scl rise"}, int'(t_sda_any < t_scl_rel), 1);
    endtask

    task automatic t_sample(input string tag, input logic sl);
        logic chg;
        chg = sda_pd;
        slave_pd = sl;
        issue(0, 0, 0, 1, 0);
        wait_done();
        check({tag, " R8 rx_bit"}, int'(rx_bit), int'(!sl));
        check({tag, " R8 sda released"}, int'(sda_pd), 0);
        if (chg) check({tag, " R8 release point"}, t_sda_rel - c0, el*es);
        check({tag, " R3 scl pull"}, t_scl_pull - c0, 8*el - 1 + 8*eh);
        check({tag, " R13 sda before scl rise"}, int'(t_sda_any < t_scl_rel), 1);
        slave_pd = 0;
    endtask

    task automatic t_rstart(input string tag);
        int su;
        issue(1, 0, 0, 0, 0);
        wait_done();
        su = 8*eh*eu + 1;
        check({tag, " R6 sda release"}, t_sda_rel - c0, el*es);
        check({tag, " R6 scl release"}, t_scl_rel - c0, 8*el - 1);
        check({tag, " R6 sda fall"}, t_sda_pull - t_scl_rel, su);
        check({tag, " R6 scl fall"}, t_scl_pull - t_sda_pull, 8*eh*(eu+1) - 1);
    endtask

    task automatic t_stop(input string tag, input logic sp, input logic sd, input logic sm);
        logic chg;
        chg = !sda_pd;
        issue(0, sp, sd, sm, 1);
        wait_done();
        if (chg) check({tag, " R7 sda pull"}, t_sda_pull - c0, el*es);
        check({tag, " R7 scl release"}, t_scl_rel - c0, 8*el - 1);
        check({tag, " R7 sda release"}, t_sda_rel - t_scl_rel, 8*eh*ep + 1);
        check({tag, " R7 done"}, t_done - t_sda_rel, 0);
        step();
        check({tag, " R7 idle lines"}, int'({scl_pd, sda_pd, busy}), 0);
    endtask

    task automatic t_idle_ignore();
        int nd;
        nd = n_done;
        issue(0, 1, 0, 0, 0);
        issue(0, 0, 1, 0, 0);
        issue(0, 0, 0, 1, 0);
        repeat (40) step();
        check("R10 no done in idle", n_done, nd);
        check("R10 lines idle", int'({scl_pd, sda_pd, busy}), 0);
    endtask

    task automatic t_busy_latch();
        int nd;
        set_cfg(3, 2, 2, 1, 2);
        nd = n_done;
        issue(1, 0, 0, 0, 0);
        repeat (10) step();
        cmd_stop = 1; cmd_send = 1; data_in = 1;
        div_word = '0; ctrl_word = '0;
        @(posedge clk);
        #1;
        cmd_stop = 0; cmd_send = 0;
        wait_done();
        check("R11 sda fall kept", t_sda_pull - c0, 8*eh*eu + 1);
        check("R11 scl fall kept", t_scl_pull - c0, 8*eh*eu + 1 + 8*eh*(eu+1) - 1);
        step();
        check("R9 done one cycle", int'(done), 0);
        repeat (20) step();
        check("R10 busy strobes ignored", n_done, nd + 1);
        check("R10 bus still held", int'({scl_pd, sda_pd, busy}), 3'b110);
        set_cfg(3, 2, 2, 1, 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        step();
        check("R1 reset lines", int'({scl_pd, sda_pd, busy, done}), 0);
        rst_n = 1;
        step();
        check("R1 after reset", int'({scl_pd, sda_pd, busy, done}), 0);

        // configuration A: l=4 h=3 s=3 u=2 p=3
        set_cfg(3, 2, 2, 1, 2);
        t_start_idle("A start");
        t_send("A send1", 1);
        t_send("A send0", 0);
        t_sample("A sample ack", 1);
        t_sample("A sample one", 0);
        t_send("A send0b", 0);
        t_rstart("A rstart");
        t_send("A send1b", 1);
        t_stop("A stop", 1, 0, 0);
        t_idle_ignore();

        // zero fields: l=2 h=2 s=1 u=1 p=1
        set_cfg(0, 0, 0, 0, 0);
        t_start_idle("R2 zero start");
        t_send("R2 zero send1", 1);
        t_stop("R2 zero stop", 1, 0, 0);

        // boundary: s field 7, maximum u and p
        set_cfg(5, 1, 7, 3, 3);
        t_start_idle("R4 max start");
        t_send("R4 max send1", 1);
        t_send("R4 max send0", 0);
        t_send("R4 max send1b", 1);
        t_stop("R4 max stop", 1, 0, 0);

        // busy strobes ignored, settings captured at acceptance
        t_busy_latch();

        // priority: stop over send and sample
        t_stop("R12 stop wins", 1, 1, 1);
        // priority: start over stop on an idle bus
        issue(1, 1, 0, 0, 0);
        wait_done();
        check("R12 start wins sda", t_sda_pull - c0, 8*eh*eu + 1);
        // priority: send over sample
        issue(0, 0, 1, 1, 0);
        wait_done();
        check("R12 send wins sda", int'(sda_pd), 1);
        check("R12 send wins no change", t_sda_any, -1);
        t_stop("R12 final stop", 1, 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule